// File: doc/BRIEF.md
# Split-Write Character Bank Mapper

This block holds eight 9-bit bank numbers that place the 8 KiB picture-pattern space seen by the video processor onto a character ROM of up to 512 KiB, in 1 KiB steps. The CPU side cannot load a bank number in one write. It sets each number in two strobes: one carries the four low bits and the other carries the five high bits. An upstream address decoder turns CPU writes into a window index, a low/high flag and a strobe. Window n is the n-th low/high register pair in ascending CPU address order.

On the video side, bits 12:10 of the incoming pattern address pick a window. The block then drives ROM address bits 18:10 from that window's bank number. Bits 9:0 pass straight through. The output path is purely combinational, so a new pattern address is translated in the same cycle. Only the register updates wait for a clock edge.

Top module: `chr_bank_map`

## Requirements
- R1: After reset every bank number is zero, so `chr_addr` equals `{9'b0, ppu_addr[9:0]}` for any pattern address.
- R2: A strobe with `wr_hi`=0 sets bits 3:0 of bank `wr_idx` to `wr_data[3:0]`. The new value is visible on `chr_addr[13:10]` from the clock edge that samples the strobe.
- R3: A strobe with `wr_hi`=1 sets bits 8:4 of bank `wr_idx` to `wr_data[4:0]`. The new value is visible on `chr_addr[18:14]` from the clock edge that samples the strobe.
- R4: A low-part write leaves bits 8:4 of that bank unchanged.
- R5: A high-part write leaves bits 3:0 of that bank unchanged. Together with R4, this means the two halves may be written in either order.
- R6: Data bits 7:4 are ignored on a low-part write, and data bits 7:5 are ignored on a high-part write.
- R7: `ppu_addr[12:10]` = n selects bank n. Bank 0 covers pattern addresses 0x0000-0x03FF, and each following bank covers the next 1 KiB, up to bank 7 at 0x1C00-0x1FFF.
- R8: `chr_addr[9:0]` always equals `ppu_addr[9:0]`.
- R9: `chr_addr` follows a change of `ppu_addr` in the same cycle, with no clock edge needed.
- R10: A write to one bank leaves the other seven banks unchanged.
- R11: While `wr_en` is low, no bank changes, whatever `wr_idx`, `wr_hi` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bank registers |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_idx | input | 3 | Window whose bank number is written |
| wr_hi | input | 1 | 0 writes bank bits 3:0, 1 writes bank bits 8:4 |
| wr_data | input | 8 | CPU data byte |
| ppu_addr | input | 13 | Pattern-space address from the video processor |
| chr_addr | output | 19 | Character ROM address: bank number over bits 18:10, offset over bits 9:0 |

## Verification
The bench first sweeps every window at offsets 0, 0x3FF and a mid value straight after reset. This separates a wrong window decode from a broken pass-through. Banks are then loaded with different values. Some get the low part first, some the high part first, and some are rewritten one half at a time. This exposes halves that clobber each other or take the wrong data bits. Writes carry junk in their unused data bits. A burst of data and index toggling with the strobe low must change nothing. A final sweep of all windows after a single-bank update catches writes that reach a neighbouring bank.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;
    parameter int NUM_WIN  = 8;
    parameter int LO_W     = 4;
    parameter int HI_W     = 5;
    parameter int OFS_W    = 10;
    parameter int DATA_W   = 8;

    localparam int BANK_W  = LO_W + HI_W;
    localparam int IDX_W   = $clog2(NUM_WIN);
    localparam int PPU_W   = OFS_W + IDX_W;
    localparam int ROM_W   = OFS_W + BANK_W;

    typedef logic [BANK_W-1:0]              bank_t;
    typedef logic [NUM_WIN-1:0][BANK_W-1:0] bank_arr_t;

    typedef struct packed {
        bank_arr_t bank;
    } bank_state_t;
endpackage

// File: rtl/chr_bank_regfile.sv
module chr_bank_regfile
    import chr_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output bank_arr_t         banks
);
    bank_state_t st_d, st_q;
    logic [NUM_WIN-1:0] hit_lo, hit_hi;

    // per-window strobe decode
    genvar g;
    generate
        for (g = 0; g < NUM_WIN; g++) begin : g_dec
            assign hit_lo[g] = wr_en && !wr_hi && (wr_idx == IDX_W'(g));
            assign hit_hi[g] = wr_en &&  wr_hi && (wr_idx == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (hit_lo[w])
                st_d.bank[w][LO_W-1:0] = wr_data[LO_W-1:0];
            if (hit_hi[w])
                st_d.bank[w][BANK_W-1:LO_W] = wr_data[HI_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign banks = st_q.bank;
endmodule

// File: rtl/chr_window_select.sv
module chr_window_select
    import chr_bank_pkg::*;
(
    input  bank_arr_t         banks,
    input  logic [IDX_W-1:0]  win,
    output bank_t             bank_sel
);
    always_comb begin
        bank_sel = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (win == IDX_W'(w))
                bank_sel = banks[w];
        end
    end
endmodule

// File: rtl/chr_bank_map.sv
module chr_bank_map
    import chr_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PPU_W-1:0]  ppu_addr,
    output logic [ROM_W-1:0]  chr_addr
);
    bank_arr_t banks;
    bank_t     bank_sel;

    chr_bank_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .banks   (banks)
    );

    chr_window_select u_sel (
        .banks    (banks),
        .win      (ppu_addr[PPU_W-1:OFS_W]),
        .bank_sel (bank_sel)
    );

    assign chr_addr = {bank_sel, ppu_addr[OFS_W-1:0]};
endmodule

// File: rtl/chr_bank_map_chk.sv
module chr_bank_map_chk
    import chr_bank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              wr_hi,
    input logic [DATA_W-1:0] wr_data,
    input logic [PPU_W-1:0]  ppu_addr,
    input logic [ROM_W-1:0]  chr_addr
);
    AST_OFS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[OFS_W-1:0] == ppu_addr[OFS_W-1:0]); // R8

    AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi && ppu_addr[PPU_W-1:OFS_W] == wr_idx) |=>
        ($stable(ppu_addr) -> chr_addr[OFS_W+LO_W-1:OFS_W] == $past(wr_data[LO_W-1:0]))); // R2

    AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi && ppu_addr[PPU_W-1:OFS_W] == wr_idx) |=>
        ($stable(ppu_addr) -> chr_addr[ROM_W-1:OFS_W+LO_W] == $past(wr_data[HI_W-1:0]))); // R3

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=>
        ($stable(ppu_addr) -> $stable(chr_addr[ROM_W-1:OFS_W+LO_W]))); // R4

    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=>
        ($stable(ppu_addr) -> $stable(chr_addr[OFS_W+LO_W-1:OFS_W]))); // R5

    AST_OTHER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ppu_addr[PPU_W-1:OFS_W] != wr_idx) |=>
        ($stable(ppu_addr) -> $stable(chr_addr))); // R10

    AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ppu_addr) -> $stable(chr_addr))); // R11
endmodule

bind chr_bank_map chr_bank_map_chk u_chk (.*);

// File: tb/sim_chr_bank_map.sv
`timescale 1ns/1ps
module sim_chr_bank_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [12:0] ppu_addr = '0;
    logic [18:0] chr_addr;

    typedef struct {
        logic [12:0] addr;
        logic [18:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic [8:0]  model [8];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    chr_bank_map u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_hi(wr_hi), .wr_data(wr_data), .ppu_addr(ppu_addr), .chr_addr(chr_addr)
    );

    // driver: register write, model updated from the requirements
    task automatic cpu_wr(input logic [2:0] idx, input logic hi, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'hA5;
        if (hi) model[idx][8:4] = d[4:0];
        else    model[idx][3:0] = d[3:0];
    endtask

    // driver: present an address, no clock edge in between (R9)
    task automatic probe(input logic [12:0] a, input string tag);
        item_t it;
        ppu_addr = a;
        it.addr = a;
        it.exp  = {model[a[12:10]], a[9:0]};
        it.tag  = tag;
        sb_q.push_back(it);
        #1;
    endtask

    // monitor
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            #0.5;
            it = sb_q.pop_front();
            n_chk++;
            if (chr_addr !== it.exp) begin
                n_bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, chr_addr, it.exp);
            end
        end
    end

    task automatic sweep(input string tag);
        for (int w = 0; w < 8; w++) begin
            probe({w[2:0], 10'h000}, tag);
            probe({w[2:0], 10'h3FF}, tag);
            probe({w[2:0], 10'h1B6}, tag);
        end
    endtask

    initial begin
        for (int w = 0; w < 8; w++) model[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sweep("R1");                          // reset state, R7/R8 decode
        // R2 low part alone, junk in bits 7:4 (R6)
        cpu_wr(3'd0, 1'b0, 8'hF9);
        @(negedge clk); probe(13'h0000, "R2"); probe(13'h0155, "R6");
        // R3 high part alone, junk in bits 7:5 (R6)
        cpu_wr(3'd1, 1'b1, 8'hF3);
        @(negedge clk); probe(13'h0400, "R3"); probe(13'h07FF, "R6");
        // R4: high then low on bank 2; low must not disturb high
        cpu_wr(3'd2, 1'b1, 8'h15);
        cpu_wr(3'd2, 1'b0, 8'h0C);
        @(negedge clk); probe(13'h0A00, "R4");
        // R5: low then high on bank 3; high must not disturb low
        cpu_wr(3'd3, 1'b0, 8'h07);
        cpu_wr(3'd3, 1'b1, 8'h1E);
        @(negedge clk); probe(13'h0C01, "R5");
        // rewrite single halves
        cpu_wr(3'd2, 1'b0, 8'h03);
        @(negedge clk); probe(13'h0BFF, "R4");
        cpu_wr(3'd3, 1'b1, 8'h01);
        @(negedge clk); probe(13'h0E00, "R5");
        // fill the upper windows with distinct values
        for (int w = 4; w < 8; w++) begin
            cpu_wr(w[2:0], 1'b0, 8'(w * 3 + 1));
            cpu_wr(w[2:0], 1'b1, 8'(w * 5 + 2));
        end
        sweep("R7");
        // R11: toggling with strobe low changes nothing
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            wr_idx = k[2:0]; wr_hi = k[0]; wr_data = 8'(k * 37);
        end
        @(negedge clk);
        sweep("R11");
        // R10: one bank written, others unchanged
        cpu_wr(3'd5, 1'b1, 8'h1F);
        cpu_wr(3'd5, 1'b0, 8'h0F);
        @(negedge clk);
        sweep("R10");
        // R9/R8: address walk without waiting for a clock edge
        for (int a = 0; a < 8192; a += 509)
            probe(13'(a), "R9");
        wait (sb_q.size() == 0);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule